// File: doc/BRIEF.md
# Interrupt Polarity Inverter Bank

This block sits between a set of external interrupt request lines and an interrupt controller that only recognises active-high levels and rising edges. Each line passes through its own XOR gate, and a programmable bit per line decides whether that line is inverted. Inverting a line turns an active-low level source into an active-high one, and it turns a falling-edge source into a rising-edge one. The downstream controller can then accept both kinds of source.

Software programs the inversion bits through a small 32-bit register port. The bits are packed 32 lines to a word, and the first word sits at byte offset 0x04 of a 0x200-byte window. Every word reads back exactly what was last written to it. This lets software change single bits by read-modify-write, and it lets software save and restore the whole bank across power states. The inversion path is combinational by default, so it adds no latency to the interrupt lines. A parameter can select a registered output stage instead.

Top module: `irq_polarity_bank`

## Requirements
- R1: After reset every configuration bit is 0, so every output equals its input, and rsp_valid is 0.
- R2: Line n is governed by bit (n mod 32) of the word at byte offset 0x04 + (n div 32)*4. With 256 lines, the words occupy offsets 0x04 to 0x20.
- R3: A configuration bit of 1 drives the output to the inverse of its input. A bit of 0 passes the input through unchanged. This holds for every input pattern.
- R4: A write (req_valid=1, req_write=1) takes effect at the clock edge that accepts it. The outputs reflect the new bits right after that edge.
- R5: A read (req_valid=1, req_write=0) raises rsp_valid for exactly one cycle, on the cycle after it is accepted. rsp_rdata then holds the value last written to that word. No response appears without a read.
- R6: Offset 0x00 and offsets 0x24 to 0x1FC read as zero, and writes to them change no configuration bit.
- R7: On an inverted line, a falling edge at the input appears as a rising edge at the output. On a line that is not inverted, edges keep their direction.
- R8: Transfers are full words only. Address bits [1:0] are ignored, so byte offset 0x06 addresses the same word as 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted; always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | 256 | Raw interrupt lines (already synchronous) |
| irq_out | output | 256 | Polarity-corrected lines to the controller |

## Verification
The bench builds the block with its defaults: 256 lines, a 32-bit word, a 9-bit address and the combinational output path. These values bring the full eight-word map within reach, together with the unmapped space both below and above it. The last word (offset 0x20) and the first unmapped word after it (0x24) are both exercised. Every one of the 256 outputs is compared against an independent model of the bit that should govern it. This catches any error in how lines are packed into words.

// File: rtl/pib_pkg.sv
package pib_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/pib_decode.sv
module pib_decode #(
  parameter int ADDR_W    = 9,
  parameter int CFG_BASE  = 4,
  parameter int NUM_WORDS = 8,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [WIDX_W-1:0] widx
);
  localparam int BASE_IDX = CFG_BASE / 4;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic             unused_bits;

  // Word index; the two byte-lane bits play no part (full-word transfers).
  assign idx = addr[ADDR_W-1:2];
  assign rel = idx - IDX_W'(BASE_IDX);
  assign hit = (int'(idx) >= BASE_IDX) && (int'(idx) < BASE_IDX + NUM_WORDS);
  assign widx = rel[WIDX_W-1:0];
  assign unused_bits = ^{addr[1:0], rel};
endmodule

// File: rtl/pib_cfg_bank.sv
module pib_cfg_bank
  import pib_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int FLAT_W   = DATA_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic              hit,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [FLAT_W-1:0] cfg_flat
);
  logic [DATA_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_WORDS; k++) words[k] <= '0;
    end else if (kind == ACC_WRITE && hit) begin
      words[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (kind == ACC_READ);
      rsp_rdata <= (kind == ACC_READ && hit) ? words[widx] : '0;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
    assign cfg_flat[g*DATA_W +: DATA_W] = words[g];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_WRITE && hit) |=> (words[$past(widx)] == $past(wdata))); // R4
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_READ) |=> rsp_valid); // R5
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    (kind != ACC_READ) |=> !rsp_valid); // R5
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_READ && !hit) |=> (rsp_rdata == '0)); // R6
  AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_WRITE && !hit) |=> $stable(cfg_flat)); // R6
endmodule

// File: rtl/pib_invert.sv
module pib_invert #(
  parameter int NUM_LINES = 256,
  parameter bit REG_OUT   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic [NUM_LINES-1:0] flip,
  output logic [NUM_LINES-1:0] lines_out
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) lines_out <= '0;
      else     lines_out <= lines_in ^ flip;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign lines_out = lines_in ^ flip;
  end
endmodule

// File: rtl/irq_polarity_bank.sv
module irq_polarity_bank
  import pib_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 9,
  parameter int CFG_BASE  = 4,
  parameter bit REG_OUT   = 1'b0,
  localparam int NUM_WORDS = NUM_LINES / DATA_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  acc_kind_t         kind;
  logic              hit;
  logic [WIDX_W-1:0] widx;
  logic [NUM_LINES-1:0] cfg_flat;

  assign req_ready = 1'b1;
  assign kind = !req_valid ? ACC_NONE : (req_write ? ACC_WRITE : ACC_READ);

  pib_decode #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .NUM_WORDS(NUM_WORDS)
  ) u_decode (
    .addr(req_addr), .hit(hit), .widx(widx)
  );

  pib_cfg_bank #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
  ) u_cfg (
    .clk(clk), .rst(rst), .kind(kind), .hit(hit), .widx(widx),
    .wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_flat(cfg_flat)
  );

  pib_invert #(
    .NUM_LINES(NUM_LINES), .REG_OUT(REG_OUT)
  ) u_inv (
    .clk(clk), .rst(rst), .lines_in(irq_in), .flip(cfg_flat),
    .lines_out(irq_out)
  );
endmodule

// File: tb/irq_polarity_bank_tb.sv
module irq_polarity_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 256;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [8:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NW];

  localparam logic [31:0] PAT [NW] = '{
    32'h8000_0001, 32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h1234_5678,
    32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0000, 32'hC001_D00D};

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_polarity_bank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_in(irq_in), .irq_out(irq_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    chk(rsp_valid == 1'b1, req, {31'b0, rsp_valid}, 32'h1);
    chk(rsp_rdata == exp, req, rsp_rdata, exp);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, req, {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic check_lines(input string req);
    int bad = -1;
    for (int n = 0; n < NL; n++)
      if (irq_out[n] !== (irq_in[n] ^ model[n/32][n%32]) && bad < 0) bad = n;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {31'b0, irq_out[bad]},
             {31'b0, irq_in[bad] ^ model[bad/32][bad%32]});
  endtask

  initial begin
    for (int k = 0; k < NW; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", {31'b0, rsp_valid}, 0);
    irq_in = {8{32'h5AC3_0F96}};
    #1 check_lines("R1");

    // Table walk: write each word, then read all back (R2, R5)
    for (int k = 0; k < NW; k++) begin
      wr(9'(4 + 4*k), PAT[k]);
      model[k] = PAT[k];
      #1 check_lines("R4"); // visible right after the accepting edge
    end
    for (int k = 0; k < NW; k++) rd(9'(4 + 4*k), PAT[k], "R5");

    // R3 under several input patterns
    irq_in = '0;            #1 check_lines("R3");
    irq_in = '1;            #1 check_lines("R3");
    irq_in = {128{2'b10}};  #1 check_lines("R3");
    irq_in = {8{32'h1357_9BDF}}; #1 check_lines("R3");

    // R2 single-bit mapping: line 200 -> word 6 (offset 0x1C) bit 8
    wr(9'h1C, 32'h0000_0100); model[6] = 32'h0000_0100;
    irq_in = '0;
    #1 chk(irq_out[200] == 1'b1, "R2", {31'b0, irq_out[200]}, 1);
    chk(irq_out[199] == 1'b0 && irq_out[201] == 1'b0, "R2",
        {30'b0, irq_out[201], irq_out[199]}, 0);
    check_lines("R2");

    // R6 holes: 0x00, 0x24, 0x1FC
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h024, 32'hFFFF_FFFF);
    wr(9'h1FC, 32'hFFFF_FFFF);
    #1 check_lines("R6");
    rd(9'h000, 32'h0, "R6");
    rd(9'h024, 32'h0, "R6");
    rd(9'h1FC, 32'h0, "R6");
    rd(9'h020, PAT[7], "R6");

    // R8 low address bits ignored
    wr(9'h006, 32'h0000_00A5); model[0] = 32'h0000_00A5;
    rd(9'h004, 32'h0000_00A5, "R8");
    rd(9'h007, 32'h0000_00A5, "R8");
    #1 check_lines("R8");

    // R7 edge direction: line 0 inverted (bit0 of 0xA5=1), line 1 not (bit1=0)
    irq_in = '0; irq_in[0] = 1'b1; irq_in[1] = 1'b1;
    #1 chk(irq_out[0] == 1'b0 && irq_out[1] == 1'b1, "R7",
           {30'b0, irq_out[1], irq_out[0]}, 32'h2);
    irq_in[0] = 1'b0; irq_in[1] = 1'b0;
    #1 chk(irq_out[0] == 1'b1 && irq_out[1] == 1'b0, "R7",
           {30'b0, irq_out[1], irq_out[0]}, 32'h1);

    // R1 again: reset clears all bits
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < NW; k++) model[k] = '0;
    irq_in = {8{32'hF00D_CAFE}};
    #1 check_lines("R1");
    rd(9'h020, 32'h0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule